// File: doc/BRIEF.md
# Asynchronous ROM Fetch Controller

This block lets a synchronous host fetch single bytes from an external asynchronous read-only memory of 16K locations by 8 bits. The memory has two active-low strobes, a chip enable and an output enable. The host presents a 14-bit address with a request while `ready` is high. The controller then places the address and lowers the chip enable in the same cycle. It lowers the output enable late, just early enough that the output-enable access delay ends at the same moment as the address access delay. It captures the data bus on that edge and returns the byte with a one-cycle `rvalid` pulse.

All delays are whole clock cycles set by parameters, one set per speed grade and clock rate. `ACC_CYC` covers the address and chip-enable access time, `OE_CYC` covers the output-enable access time, and `REL_CYC` covers the time the memory needs to float its outputs after a strobe rises. Both strobes rise on the capture edge. `ready` stays low for a further `REL_CYC` cycles so that the bus turns around before the next access. Between accesses both strobes are held high, which keeps the memory in standby.

Top module: `rom_fetch_ctrl`

## Requirements
- R1: A synchronous reset, applied at any time including mid-access, drives `rom_ce_n` and `rom_oe_n` high, clears `rom_addr` to 0, sets `ready` to 1 and holds `rvalid` at 0 until a new request is accepted.
- R2: While no access is in progress, `rom_ce_n` and `rom_oe_n` are both 1, and whenever `ready` is 1 both strobes are 1.
- R3: A request is accepted on a rising edge where `req` and `ready` are both 1. After that edge `rom_ce_n` is 0, `rom_addr` equals the accepted `addr` and `ready` is 0.
- R4: `rom_ce_n` stays 0 for exactly `ACC_CYC` cycles after acceptance. `rom_oe_n` stays 1 for the first `ACC_CYC-OE_CYC` of those cycles, or for none of them when `OE_CYC >= ACC_CYC`, and is 0 for the rest.
- R5: `rom_dq` is captured on the rising edge `ACC_CYC` cycles after acceptance. In the following cycle `rvalid` is 1 for exactly one cycle and `rdata` holds the captured byte.
- R6: Both strobes rise on the capture edge, so they are 1 in the cycle where `rvalid` is 1.
- R7: After the capture edge `ready` stays 0 for `REL_CYC` cycles and then returns to 1. A request made while `ready` is 0 is ignored: it neither lowers `rom_ce_n` nor changes `rom_addr`.
- R8: `rom_oe_n` is never 0 while `rom_ce_n` is 1.
- R9: `rom_addr` does not change while `rom_ce_n` stays 0.
- R10: `rvalid` is 0 in every cycle except the single cycle following the capture edge of an accepted access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Host read request |
| addr | input | ADDR_W | Host byte address |
| ready | output | 1 | Controller can accept a request |
| rdata | output | DATA_W | Fetched byte |
| rvalid | output | 1 | One-cycle pulse marking `rdata` valid |
| rom_addr | output | ADDR_W | Address bus to the memory |
| rom_ce_n | output | 1 | Memory chip enable, active low |
| rom_oe_n | output | 1 | Memory output enable, active low |
| rom_dq | input | DATA_W | Memory data bus |

## Verification
The hardest case to reach from the ports is data that looks right but was sampled before the memory could have driven it. A controller that captures one cycle early still returns a plausible byte if the bench model always drives the correct value. To expose this, the bench memory model counts how long the address, the chip enable and the output enable have each been held. It returns the bitwise complement of the stored byte unless all three access delays have elapsed, so any early capture or early strobe shows up as a wrong `rdata`. Requests held high through the busy window, reads of the same address back to back, and a reset in the middle of an access cover the ignore and recovery paths.

// File: rtl/rom_fetch_pkg.sv
package rom_fetch_pkg;

    // Sequencer phases of one fetch
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // strobes high, memory in standby
        PH_ACCESS = 2'd1,  // chip enabled, waiting out access delay
        PH_TURN   = 2'd2   // strobes released, bus floating out
    } fetch_phase_e;

endpackage

// File: rtl/rom_fetch_timer.sv
module rom_fetch_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/rom_fetch_capture.sv
module rom_fetch_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              vld_d, vld_q;

    always_comb begin
        data_d = load ? din : data_q;
        vld_d  = load;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign dout  = data_q;
    assign valid = vld_q;

    // R5: a capture never yields two valid cycles in a row
    p_rvalid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);

endmodule

// File: rtl/rom_fetch_ctrl.sv
module rom_fetch_ctrl #(
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 7,
    parameter int OE_CYC  = 4,
    parameter int REL_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [DATA_W-1:0] rom_dq
);
    import rom_fetch_pkg::*;

    // Cycles from address launch until the output enable drops
    localparam int OE_LEAD = (ACC_CYC > OE_CYC) ? (ACC_CYC - OE_CYC) : 0;
    localparam int SPAN    = (ACC_CYC > REL_CYC) ? ACC_CYC : REL_CYC;
    localparam int CNT_W   = $clog2(SPAN + 1);

    // Timer values seen in the cycle before each event edge
    localparam logic [CNT_W-1:0] OE_AT  = CNT_W'((OE_LEAD > 0) ? (OE_LEAD - 1) : 0);
    localparam logic [CNT_W-1:0] CAP_AT = CNT_W'((ACC_CYC > 0) ? (ACC_CYC - 1) : 0);
    localparam logic [CNT_W-1:0] REL_AT = CNT_W'((REL_CYC > 0) ? (REL_CYC - 1) : 0);
    localparam bit               OE_WITH_CE = (OE_LEAD == 0);
    localparam bit               NO_TURN    = (REL_CYC == 0);

    initial begin
        if (ACC_CYC < 1) $error("ACC_CYC must be at least 1");
        if (OE_CYC < 1)  $error("OE_CYC must be at least 1");
    end

    typedef struct packed {
        fetch_phase_e      ph;
        logic [ADDR_W-1:0] addr;
        logic              ce_n;
        logic              oe_n;
        logic              rdy;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             tmr_clear;
    logic             cap_load;
    logic [CNT_W-1:0] tmr_cnt;

    rom_fetch_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .count (tmr_cnt)
    );

    rom_fetch_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk   (clk),
        .rst   (rst),
        .load  (cap_load),
        .din   (rom_dq),
        .dout  (rdata),
        .valid (rvalid)
    );

    always_comb begin
        seq_d     = seq_q;
        tmr_clear = 1'b0;
        cap_load  = 1'b0;

        unique case (seq_q.ph)
            PH_IDLE: begin
                seq_d.ce_n = 1'b1;
                seq_d.oe_n = 1'b1;
                if (req && seq_q.rdy) begin
                    seq_d.ph   = PH_ACCESS;
                    seq_d.addr = addr;
                    seq_d.ce_n = 1'b0;
                    seq_d.oe_n = !OE_WITH_CE;
                    seq_d.rdy  = 1'b0;
                    tmr_clear  = 1'b1;
                end
            end

            PH_ACCESS: begin
                if (!OE_WITH_CE && tmr_cnt == OE_AT) begin
                    seq_d.oe_n = 1'b0;
                end
                if (tmr_cnt == CAP_AT) begin
                    // sample on this edge, then release both strobes
                    cap_load   = 1'b1;
                    seq_d.ce_n = 1'b1;
                    seq_d.oe_n = 1'b1;
                    tmr_clear  = 1'b1;
                    if (NO_TURN) begin
                        seq_d.ph  = PH_IDLE;
                        seq_d.rdy = 1'b1;
                    end else begin
                        seq_d.ph  = PH_TURN;
                    end
                end
            end

            PH_TURN: begin
                if (tmr_cnt == REL_AT) begin
                    seq_d.ph  = PH_IDLE;
                    seq_d.rdy = 1'b1;
                end
            end

            default: begin
                seq_d.ph   = PH_IDLE;
                seq_d.ce_n = 1'b1;
                seq_d.oe_n = 1'b1;
                seq_d.rdy  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.ph   <= PH_IDLE;
            seq_q.addr <= '0;
            seq_q.ce_n <= 1'b1;
            seq_q.oe_n <= 1'b1;
            seq_q.rdy  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready    = seq_q.rdy;
    assign rom_addr = seq_q.addr;
    assign rom_ce_n = seq_q.ce_n;
    assign rom_oe_n = seq_q.oe_n;

    // R8: output enable only inside a chip-enable window
    p_oe_inside_ce_r8: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> !rom_ce_n);

    // R9: address held for the whole enabled window
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));

    // R2: accepting means the bus is parked
    p_ready_parked_r2: assert property (@(posedge clk) disable iff (rst)
        ready |-> (rom_ce_n && rom_oe_n));

    // R3: an accepted request launches address and chip enable together
    p_accept_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> (!rom_ce_n && !ready && rom_addr == $past(addr)));

    // R6: returned data only after the strobes are released
    p_release_on_capture_r6: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (rom_ce_n && rom_oe_n));

endmodule

// File: tb/rom_fetch_ctrl_tb.sv
module rom_fetch_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ACC     = 7;
    localparam int OE      = 4;
    localparam int REL     = 3;
    localparam int OE_LEAD = (ACC > OE) ? (ACC - OE) : 0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [13:0] addr = '0;
    logic        ready;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [13:0] rom_addr;
    logic        rom_ce_n;
    logic        rom_oe_n;
    logic [7:0]  rom_dq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rom_fetch_ctrl #(
        .ADDR_W  (14),
        .DATA_W  (8),
        .ACC_CYC (ACC),
        .OE_CYC  (OE),
        .REL_CYC (REL)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .addr     (addr),
        .ready    (ready),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .rom_addr (rom_addr),
        .rom_ce_n (rom_ce_n),
        .rom_oe_n (rom_oe_n),
        .rom_dq   (rom_dq)
    );

    function automatic logic [7:0] mem_byte(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], a[13:12]} ^ 8'h3C;
    endfunction

    // Memory model: completed periods each input has been held
    int          a_held = 0;
    int          ce_held = 0;
    int          oe_held = 0;
    logic [13:0] a_seen = '0;

    always_ff @(posedge clk) begin
        a_seen  <= rom_addr;
        a_held  <= (rom_addr == a_seen) ? ((a_held < 255) ? a_held + 1 : a_held) : 1;
        ce_held <= rom_ce_n ? 0 : ((ce_held < 255) ? ce_held + 1 : ce_held);
        oe_held <= rom_oe_n ? 0 : ((oe_held < 255) ? oe_held + 1 : oe_held);
    end

    logic dq_good;
    assign dq_good = !rom_ce_n && !rom_oe_n && (a_held + 1 >= ACC)
                     && (ce_held + 1 >= ACC) && (oe_held + 1 >= OE);
    assign rom_dq  = dq_good ? mem_byte(rom_addr) : ~mem_byte(rom_addr);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_cycles(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk(rom_ce_n && rom_oe_n, "R2 strobes parked", {rom_ce_n, rom_oe_n}, 3);
            chk(!rvalid, "R10 no stray rvalid", rvalid, 0);
        end
    endtask

    // Called at a falling edge with ready high
    task automatic do_read(input logic [13:0] a, input bit hold_busy);
        chk(ready, "R7 ready before request", ready, 1);
        req  = 1'b1;
        addr = a;
        @(posedge clk);
        for (int n = 1; n <= ACC + REL + 1; n++) begin
            @(negedge clk);
            if (n == 1) begin
                chk(!rom_ce_n, "R3 ce low after accept", rom_ce_n, 0);
                chk(rom_addr == a, "R3 address launched", rom_addr, a);
                chk(!ready, "R3 ready dropped", ready, 0);
                if (hold_busy) addr = ~a;
                else req = 1'b0;
            end
            if (n <= ACC) begin
                chk(!rom_ce_n, "R4 ce window", rom_ce_n, 0);
                chk(rom_oe_n == (n <= OE_LEAD), "R4 oe timing", rom_oe_n, (n <= OE_LEAD));
                chk(rom_addr == a, "R9 address held", rom_addr, a);
                chk(!rvalid, "R10 rvalid early", rvalid, 0);
            end
            if (n == ACC + 1) begin
                chk(rvalid, "R5 rvalid", rvalid, 1);
                chk(rdata == mem_byte(a), "R5 rdata", rdata, mem_byte(a));
                chk(rom_ce_n && rom_oe_n, "R6 strobes released", {rom_ce_n, rom_oe_n}, 3);
            end
            if (n > ACC && n <= ACC + REL) begin
                chk(!ready, "R7 turnaround ready", ready, 0);
                chk(rom_ce_n, "R7 busy request ignored", rom_ce_n, 1);
            end
            if (n == ACC + REL) req = 1'b0;
            if (n == ACC + REL + 1) begin
                chk(ready, "R7 ready back", ready, 1);
                chk(!rvalid, "R5 single pulse", rvalid, 0);
                chk(rom_addr == a, "R7 address untouched", rom_addr, a);
                chk(rom_ce_n, "R7 no late launch", rom_ce_n, 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(rom_ce_n && rom_oe_n, "R1 strobes", {rom_ce_n, rom_oe_n}, 3);
        chk(rom_addr == 0, "R1 address", rom_addr, 0);
        chk(ready, "R1 ready", ready, 1);
        chk(!rvalid, "R1 rvalid", rvalid, 0);
        rst = 1'b0;
        idle_cycles(4);

        // Sweep low bytes, mostly back to back
        for (int a = 0; a < 256; a++) begin
            do_read(14'(a), 1'b0);
            if (a % 16 == 15) idle_cycles(2);
        end

        // Walking ones and zeros over every address bit
        for (int b = 0; b < 14; b++) begin
            do_read(14'(1 << b), 1'b0);
            do_read(~14'(1 << b), 1'b0);
        end

        // Requests held through busy windows (R7)
        do_read(14'h3FFF, 1'b1);
        do_read(14'h1234, 1'b1);

        // Same address twice
        do_read(14'h0005, 1'b0);
        do_read(14'h0005, 1'b0);
        idle_cycles(3);

        // R1: reset in the middle of an access
        req  = 1'b1;
        addr = 14'h2AAA;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        chk(!rom_ce_n, "R3 mid-reset launch", rom_ce_n, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(rom_ce_n && rom_oe_n, "R1 mid-access strobes", {rom_ce_n, rom_oe_n}, 3);
        chk(rom_addr == 0, "R1 mid-access address", rom_addr, 0);
        chk(ready, "R1 mid-access ready", ready, 1);
        chk(!rvalid, "R1 mid-access rvalid", rvalid, 0);
        rst = 1'b0;
        idle_cycles(ACC + 3);
        do_read(14'h2AAA, 1'b0);
        idle_cycles(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule